// File: doc/BRIEF.md
# Active-Low Interrupt Aggregator

This block merges a set of active-low interrupt request lines, one per downstream channel, into a single shared interrupt. The shared pin is open-drain, so the block drives an output-enable that pulls the line low whenever at least one channel is requesting service. Every request line is brought into the clock domain through a two-flop synchronizer and then passed through a counter-based filter. The filter only accepts a new level after the line has held that level for a programmable number of clock cycles. This rejects short pulses and also sets fixed assert and release latencies.

All channels are monitored continuously, and no channel selection gates them. The block also supplies a per-channel status vector to the register-read path. A one-cycle capture strobe from the serial slave, issued at the start of the read data byte, samples the filtered states into a snapshot register. That register then holds steady until the next strobe, so the byte being shifted out cannot change partway through. There is no sticky latching: a channel stops being reported once its line has returned high and the filter has accepted that change.

Top module: `irq_aggregator`

## Requirements
- R1: Each input `irq_n_i[i]` is active low (0 = request). It is sampled through two flops before any use. After reset the synchronizer and filter states read inactive (high).
- R2: `irq_oe_o` is 1 (drive the shared line low) exactly when at least one filtered channel is active. It is registered and follows a change of filtered state by one cycle.
- R3: When an input falls and then stays low, with every other channel inactive, `irq_oe_o` rises at the negative edge that follows the FILT_CYCLES+3rd rising edge after the first edge that samples the low. At the default FILT_CYCLES of 64 and a 125 MHz clock, this is well within 4 µs.
- R4: When the last active input rises and stays high, `irq_oe_o` falls FILT_CYCLES+3 cycles after the first edge that samples the high. This is well within 2 µs.
- R5: A high pulse lasting fewer than FILT_CYCLES sampled cycles on an active input does not release that channel. The default of 64 cycles at 125 MHz covers 512 ns. A low pulse of the same length does not raise a request.
- R6: Every channel raises the shared interrupt on its own, whichever channel the rest of the system has selected. The block has no enable or mask.
- R7: A cycle with `capture_i` = 1 loads `status_o`, visible one cycle later. Bit i is 1 if channel i is filtered-active. Bit 0 is channel 0 and the top bit is the last channel, so the register path places bit 0 at control-register bit 4 and bit 3 at bit 7.
- R8: While `capture_i` is 0, `status_o` stays unchanged whatever the inputs do.
- R9: Several channels can be active together. Each is reported in its own status bit, and `irq_oe_o` stays 1 until the last of them has been released.
- R10: Nothing is latched. After an input returns high and its filter accepts the change, a new capture reports that channel as 0.
- R11: During and directly after reset, `irq_oe_o` and `status_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_n_i | input | NUM_CH | Per-channel interrupt requests, active low, asynchronous |
| capture_i | input | 1 | One-cycle strobe that samples the filtered states into the status register |
| irq_oe_o | output | 1 | Output-enable for the low drive of the shared open-drain interrupt |
| status_o | output | NUM_CH | Snapshot of active channels, bit i = channel i, 1 = active |

## Verification
A filtered level change reaches `irq_oe_o` exactly FILT_CYCLES+3 rising edges after the first edge that samples the new input level. That count is two synchronizer stages, FILT_CYCLES filter edges and one output register. A capture strobe shows up on `status_o` one edge later. The bench drives inputs only on falling edges and reads outputs only on falling edges. Its directed checks wait exactly FILT_CYCLES+2 edges to confirm the old value, then one more edge to confirm the new one. A behavioural model built from a sample queue and run counters predicts both outputs every cycle, which catches any shift of latency by one cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned DEF_NUM_CH      = 4;
    localparam int unsigned DEF_FILT_CYCLES = 64;

    // Converts active-low filtered levels into an active-high request vector.
    function automatic logic [DEF_NUM_CH-1:0] to_active(input logic [DEF_NUM_CH-1:0] lvl_n);
        return ~lvl_n;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    // Reset to all-ones: every line reads inactive (R1).
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{meta: '1, stable: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stable;

endmodule

// File: rtl/irq_filter.sv
module irq_filter #(
    parameter int unsigned FILT_CYCLES = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    output logic level_o
);

    localparam int unsigned CNT_W = (FILT_CYCLES > 2) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYCLES - 1);

    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] cnt;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (din_i == st_q.level) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.level = din_i;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{level: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;

    // R5: the accepted level flips only after a full run of mismatches.
    assert_filter_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.level != $past(st_q.level)) |-> ($past(st_q.cnt) == LAST));

    // R1: a flip always moves toward the synchronized input level.
    assert_filter_target_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.level != $past(st_q.level)) |-> (st_q.level == $past(din_i)));

endmodule

// File: rtl/irq_snapshot.sv
module irq_snapshot #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             capture_i,
    input  logic [WIDTH-1:0] active_i,
    output logic [WIDTH-1:0] status_o
);

    typedef struct packed {
        logic [WIDTH-1:0] snap;
    } snap_t;

    snap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture_i) begin
            st_d.snap = active_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{snap: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.snap;

    // R8: without a strobe the snapshot does not move.
    assert_status_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !capture_i |=> $stable(status_o));

    // R7: a strobe loads the active vector seen at that edge.
    assert_status_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        capture_i |=> (status_o == $past(active_i)));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_CH      = DEF_NUM_CH,
    parameter int unsigned FILT_CYCLES = DEF_FILT_CYCLES
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] irq_n_i,
    input  logic              capture_i,
    output logic              irq_oe_o,
    output logic [NUM_CH-1:0] status_o
);

    logic [NUM_CH-1:0] sync_n;
    logic [NUM_CH-1:0] filt_n;
    logic [NUM_CH-1:0] active;

    irq_sync #(.WIDTH(NUM_CH)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (irq_n_i),
        .sync_o  (sync_n)
    );

    // One glitch filter per channel; no selection gates any of them (R6).
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_filt
        irq_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .din_i   (sync_n[ch]),
            .level_o (filt_n[ch])
        );
    end

    assign active = ~filt_n;

    irq_snapshot #(.WIDTH(NUM_CH)) u_snap (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .capture_i (capture_i),
        .active_i  (active),
        .status_o  (status_o)
    );

    typedef struct packed {
        logic oe;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d    = out_q;
        out_d.oe = |active;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '{oe: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_oe_o = out_q.oe;

    // R2: the pin drive starts only when some filtered channel was active.
    assert_oe_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_oe_o) |-> ($past(filt_n) != '1));

    // R9: the pin is released only once every channel has been released.
    assert_oe_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_oe_o) |-> ($past(filt_n) == '1));

endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;

    localparam int NCH  = 4;
    localparam int FILT = 64;
    localparam int LAT  = FILT + 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] irq_n = '1;
    logic           capture = 1'b0;
    logic           oe;
    logic [NCH-1:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_aggregator #(.NUM_CH(NCH), .FILT_CYCLES(FILT)) uut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .irq_n_i   (irq_n),
        .capture_i (capture),
        .irq_oe_o  (oe),
        .status_o  (status)
    );

    // Behavioural reference: sample queue for the input delay, run counters for the filter.
    logic [NCH-1:0] hist[$];
    int             run[NCH];
    bit [NCH-1:0]   m_lvl;
    bit             m_oe;
    bit [NCH-1:0]   m_status;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {};
            hist.push_back('1);
            hist.push_back('1);
            foreach (run[i]) run[i] = 0;
            m_lvl = '1;
            m_oe = 1'b0;
            m_status = '0;
        end else begin
            logic [NCH-1:0] seen;
            bit [NCH-1:0]   old_lvl;
            seen = hist.pop_front();
            hist.push_back(irq_n);
            old_lvl = m_lvl;
            if (capture) m_status = ~old_lvl;
            m_oe = (old_lvl != '1);
            for (int i = 0; i < NCH; i++) begin
                if (seen[i] == old_lvl[i]) run[i] = 0;
                else if (run[i] == FILT - 1) begin
                    m_lvl[i] = seen[i];
                    run[i] = 0;
                end else run[i] = run[i] + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (oe !== m_oe) begin
                errors++;
                $display("FAIL R2 model: irq_oe actual %0b expected %0b at %0t", oe, m_oe, $time);
            end
            checks++;
            if (status !== m_status) begin
                errors++;
                $display("FAIL R7 model: status actual %b expected %b at %0t", status, m_status, $time);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic snap_and_check(input logic [NCH-1:0] exp, input string tag);
        capture = 1'b1;
        tick(1);
        capture = 1'b0;
        check(status === exp, tag, status, exp);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        check(oe === 1'b0, "R11 reset oe", oe, 0);
        check(status === '0, "R11 reset status", status, 0);
        // Channel 2 held low across reset release: still FILT+3 cycles (R1).
        irq_n = 4'b1011;
        rst_n = 1'b1;
        tick(LAT - 1);
        check(oe === 1'b0, "R1 filtered inactive after reset", oe, 0);
        tick(1);
        check(oe === 1'b1, "R1 assert after filter interval", oe, 1);
        irq_n = '1;
        tick(LAT + 2);
        check(oe === 1'b0, "R10 cleared without latching", oe, 0);
        snap_and_check('0, "R10 status reads clear");

        // Each channel alone raises the interrupt with exact latency (R3, R6).
        for (int ch = 0; ch < NCH; ch++) begin
            irq_n[ch] = 1'b0;
            tick(LAT - 1);
            check(oe === 1'b0, $sformatf("R3 ch%0d not yet asserted", ch), oe, 0);
            tick(1);
            check(oe === 1'b1, $sformatf("R6 ch%0d asserted", ch), oe, 1);
            snap_and_check(NCH'(1) << ch, $sformatf("R7 ch%0d status bit", ch));
            irq_n[ch] = 1'b1;
            tick(LAT - 1);
            check(oe === 1'b1, $sformatf("R4 ch%0d not yet released", ch), oe, 1);
            tick(1);
            check(oe === 1'b0, $sformatf("R4 ch%0d released", ch), oe, 0);
        end

        // Short low pulse is rejected (R5).
        irq_n[0] = 1'b0;
        tick(FILT - 1);
        irq_n[0] = 1'b1;
        tick(LAT + 4);
        check(oe === 1'b0, "R5 short low rejected", oe, 0);

        // Short high glitch on an active line does not release it (R5).
        irq_n[3] = 1'b0;
        tick(LAT + 1);
        irq_n[3] = 1'b1;
        tick(FILT - 1);
        irq_n[3] = 1'b0;
        tick(LAT + 4);
        check(oe === 1'b1, "R5 short high glitch rejected", oe, 1);
        snap_and_check(4'b1000, "R5 channel still reported");

        // Two channels together; staggered release (R9).
        irq_n[1] = 1'b0;
        tick(LAT + 1);
        snap_and_check(4'b1010, "R9 two channels reported");
        irq_n[3] = 1'b1;
        tick(LAT + 2);
        check(oe === 1'b1, "R9 held by remaining channel", oe, 1);
        // Snapshot held while inputs change (R8).
        irq_n[2] = 1'b0;
        tick(LAT + 2);
        check(status === 4'b1010, "R8 status held without strobe", status, 4'b1010);
        snap_and_check(4'b0110, "R7 new snapshot");
        irq_n = '1;
        tick(LAT - 1);
        check(oe === 1'b1, "R9 before last release", oe, 1);
        tick(1);
        check(oe === 1'b0, "R9 after last release", oe, 0);
        snap_and_check('0, "R10 all clear");

        tick(2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule